// File: doc/BRIEF.md
# Lamp Driver I2C Register Bank with Commit

This block is the serial control front end of a four-channel lamp driver. It watches sampled, already-synchronized SCL and SDA levels and recognises START, repeated START and STOP. It answers to one 7-bit bus address: five fixed upper bits plus two strap inputs. Through that address it gives read and write access to twelve byte-wide locations, and it presents the decoded configuration fields on parallel outputs for the analog section.

A write frame carries a pointer byte followed by any number of data bytes. The pointer advances after each byte moved in either direction and stops at the last location. A read frame streams bytes from the pointer. That pointer is zero unless the same bus session loaded it just before a repeated START. Per-channel level and ramp settings are written to staging copies, and they reach the channel outputs only when the commit location is written. The block reports an over-temperature event as a flag that stays set until reset. The open-drain pad is outside the block: `sda_low_o` high means the pad pulls SDA low.

Top module: `lamp_i2c_regbank`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1111 0 followed by strap_i[1] and strap_i[0]; bit 0 is the direction (0 write, 1 read). Any other address gets no acknowledge, and the rest of that frame is ignored.
- R2: After a matching address byte, and after every byte it accepts in a write frame, the block holds SDA low for the whole ninth SCL clock and releases it on the falling edge that ends that clock.
- R3: In a write frame the first byte after the address loads the pointer. Each later byte is stored at the pointed location, and the pointer then moves up by one.
- R4: The pointer never exceeds 0x0B. A pointer byte above 0x0B loads 0x0B, and further bytes keep addressing 0x0B. Writes to 0x0B change nothing, and 0x0B reads as 0x00.
- R5: A read frame that opens with START and no pointer write in the same session starts at location 0x00. Every STOP forgets a loaded pointer.
- R6: A read frame that follows a pointer write and a repeated START starts at the loaded pointer. The pointer advances after each byte sent.
- R7: Read data leaves MSB first, changing only while SCL is low. A master acknowledge (SDA low in the ninth clock) continues the stream. A master NACK makes the block stop driving until the next START.
- R8: Location 0x00 always reads 0xB2 and ignores writes. Location 0x01 reads {over-temperature flag, 6'b0, enable}. Only bit 0 (enable, output lamp_en_o) is writable.
- R9: Locations 0x06 to 0x09 are staging copies for channels 0 to 3: bits [4:0] hold the level and bits [7:5] the ramp time. They read back the staged value. The channel outputs change only when location 0x0A is written, and that write copies all four at once. 0x0A reads as 0x00.
- R10: Locations 0x02 to 0x05 store and read back whole bytes.
  - 0x02 drives el_freq_o.
  - 0x03: bit 6 drives damp_en_o, bits [3:2] drive wave_shape_o and bits [1:0] drive slope_o.
  - 0x04: bits [7:6] drive spread_o and bits [4:0] drive boost_freq_o.
  - 0x05: bit 7 drives aux_fm_o, bit 6 drives aux_follow_o, bits [5:4] drive aux_div_o and bits [3:0] drive aux_ch_en_o.
- R11: A high level on ovt_evt_i in any clock sets the over-temperature flag. No bus write clears it, including one that lands in the same clock as the event.
- R12: rst_n low clears every location, the staging copies, the channel outputs and the flag. While rst_n is low the block does not drive SDA and does not react to bus traffic.
- R13: A STOP in the middle of a byte abandons that byte without storing it, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| strap_i | input | 2 | Address strap bits (low two address bits) |
| ovt_evt_i | input | 1 | Over-temperature event |
| sda_low_o | output | 1 | 1 = pull SDA low |
| lamp_en_o | output | 1 | Lamp enable |
| el_freq_o | output | 8 | Lamp output frequency code |
| damp_en_o | output | 1 | Switch-node damping enable |
| wave_shape_o | output | 2 | Waveform shape code |
| slope_o | output | 2 | Output slope code |
| spread_o | output | 2 | Boost spread-spectrum code |
| boost_freq_o | output | 5 | Boost switching frequency code |
| aux_fm_o | output | 1 | Audio input modulates frequency (1) or amplitude (0) |
| aux_follow_o | output | 1 | Output envelope follows audio input |
| aux_div_o | output | 2 | Audio frequency divider code |
| aux_ch_en_o | output | 4 | Per-channel audio effect enable |
| ch_level_o | output | 20 | Active channel levels, 5 bits per channel, channel 0 lowest |
| ch_ramp_o | output | 12 | Active channel ramp codes, 3 bits per channel, channel 0 lowest |
| ovt_o | output | 1 | Latched over-temperature flag |

## Verification
The over-temperature event and a bus write to location 0x01 can land in the same clock. Both touch the word at that location, one through the flag bit and one through the enable bit. The bench raises ovt_evt_i for exactly the clock in which the slave sees the SCL fall that completes a data byte written to 0x01 with bit 7 clear. It then expects the flag set, the enable taken from the written byte, and a read-back of 0x80. The commit write can also share a frame with a staging write and with pointer saturation, and the bench checks the resulting channel outputs and read-back against its own model.

// File: rtl/lampreg_pkg.sv
package lampreg_pkg;
  localparam int NUM_CH   = 4;
  localparam int LVL_W    = 5;
  localparam int RT_W     = 3;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 12;
  localparam int PTR_W    = $clog2(NUM_REGS);
  localparam int CH_IW    = $clog2(NUM_CH);
  localparam int BIT_CW   = $clog2(BYTE_W) + 1;

  localparam logic [4:0]        ADDR_HI  = 5'b11110;
  localparam logic [BYTE_W-1:0] DEV_ID   = 8'hB2;

  localparam logic [PTR_W-1:0] REG_LAST = PTR_W'(NUM_REGS - 1);
  localparam logic [PTR_W-1:0] A_ID     = PTR_W'(0);
  localparam logic [PTR_W-1:0] A_SYS    = PTR_W'(1);
  localparam logic [PTR_W-1:0] A_FREQ   = PTR_W'(2);
  localparam logic [PTR_W-1:0] A_SHAPE  = PTR_W'(3);
  localparam logic [PTR_W-1:0] A_BOOST  = PTR_W'(4);
  localparam logic [PTR_W-1:0] A_AUDIO  = PTR_W'(5);
  localparam logic [PTR_W-1:0] A_CH0    = PTR_W'(6);
  localparam logic [PTR_W-1:0] A_COMMIT = PTR_W'(6 + NUM_CH);

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_ACK, PH_TX, PH_RACK
  } phase_t;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == REG_LAST) ? p : p + 1'b1;
  endfunction
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import lampreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_low_o,
  output logic              wr_stb_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [PTR_W-1:0]  ptr_o
);
  phase_t             ph_q, ph_d;
  logic [BIT_CW-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic is_addr_q, is_addr_d, rd_q, rd_d, got_ptr_q, got_ptr_d;
  logic ptr_ok_q, ptr_ok_d, drv_q, drv_d, mnack_q, mnack_d;

  localparam logic [BIT_CW-1:0] FULL = BIT_CW'(BYTE_W);
  localparam logic [BIT_CW-1:0] LAST = BIT_CW'(BYTE_W - 1);

  always_comb begin
    ph_d = ph_q; cnt_d = cnt_q; sh_d = sh_q; ptr_d = ptr_q;
    is_addr_d = is_addr_q; rd_d = rd_q; got_ptr_d = got_ptr_q;
    ptr_ok_d = ptr_ok_q; drv_d = drv_q; mnack_d = mnack_q;
    wr_stb_o = 1'b0;
    if (stop_i) begin
      ph_d = PH_IDLE; drv_d = 1'b0; got_ptr_d = 1'b0; ptr_ok_d = 1'b0;
    end else if (start_i) begin
      ph_d = PH_RX; cnt_d = '0; is_addr_d = 1'b1; got_ptr_d = 1'b0; drv_d = 1'b0;
    end else begin
      case (ph_q)
        PH_RX: begin
          if (scl_rise_i && cnt_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall_i && cnt_q == FULL) begin
            if (is_addr_q) begin
              if (sh_q[BYTE_W-1:1] == {ADDR_HI, strap_i}) begin
                is_addr_d = 1'b0; rd_d = sh_q[0]; drv_d = 1'b1; ph_d = PH_ACK;
                if (sh_q[0] && !ptr_ok_q) ptr_d = '0;
              end else begin
                ph_d = PH_IDLE;
              end
            end else begin
              drv_d = 1'b1; ph_d = PH_ACK;
              if (!got_ptr_q) begin
                ptr_d = (sh_q > BYTE_W'(REG_LAST)) ? REG_LAST : sh_q[PTR_W-1:0];
                got_ptr_d = 1'b1; ptr_ok_d = 1'b1;
              end else begin
                wr_stb_o = 1'b1;
                ptr_d = ptr_next(ptr_q);
              end
            end
          end
        end
        PH_ACK: if (scl_fall_i) begin
          cnt_d = '0;
          if (rd_q) begin
            sh_d = rd_data_i; ptr_d = ptr_next(ptr_q);
            drv_d = ~rd_data_i[BYTE_W-1]; ph_d = PH_TX;
          end else begin
            drv_d = 1'b0; ph_d = PH_RX;
          end
        end
        PH_TX: if (scl_fall_i) begin
          if (cnt_q == LAST) begin
            drv_d = 1'b0; ph_d = PH_RACK;
          end else begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b0}; cnt_d = cnt_q + 1'b1;
            drv_d = ~sh_q[BYTE_W-2];
          end
        end
        PH_RACK: begin
          if (scl_rise_i) mnack_d = sda_i;
          if (scl_fall_i) begin
            if (!mnack_q) begin
              cnt_d = '0; sh_d = rd_data_i; ptr_d = ptr_next(ptr_q);
              drv_d = ~rd_data_i[BYTE_W-1]; ph_d = PH_TX;
            end else begin
              ph_d = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      is_addr_q <= 1'b0; rd_q <= 1'b0; got_ptr_q <= 1'b0;
      ptr_ok_q <= 1'b0; drv_q <= 1'b0; mnack_q <= 1'b1;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; sh_q <= sh_d; ptr_q <= ptr_d;
      is_addr_q <= is_addr_d; rd_q <= rd_d; got_ptr_q <= got_ptr_d;
      ptr_ok_q <= ptr_ok_d; drv_q <= drv_d; mnack_q <= mnack_d;
    end
  end

  assign sda_low_o = drv_q;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = sh_q;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/lamp_regfile.sv
module lamp_regfile
  import lampreg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb_i,
  input  logic [PTR_W-1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0]       wr_data_i,
  input  logic [PTR_W-1:0]        rd_addr_i,
  input  logic                    ovt_evt_i,
  output logic [BYTE_W-1:0]       rd_data_o,
  output logic                    en_o,
  output logic                    ovt_o,
  output logic [BYTE_W-1:0]       freq_o,
  output logic [BYTE_W-1:0]       shape_o,
  output logic [BYTE_W-1:0]       boost_o,
  output logic [BYTE_W-1:0]       audio_o,
  output logic [NUM_CH*LVL_W-1:0] ch_level_o,
  output logic [NUM_CH*RT_W-1:0]  ch_ramp_o
);
  logic [NUM_CH*BYTE_W-1:0] stage_flat;
  logic [CH_IW-1:0]         ch_sel;
  logic commit_we;

  assign commit_we = wr_stb_i && (wr_addr_i == A_COMMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= 1'b0;
    else if (wr_stb_i && wr_addr_i == A_SYS) en_o <= wr_data_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovt_o <= 1'b0;
    else if (ovt_evt_i) ovt_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_o <= '0; shape_o <= '0; boost_o <= '0; audio_o <= '0;
    end else if (wr_stb_i) begin
      if (wr_addr_i == A_FREQ)  freq_o  <= wr_data_i;
      if (wr_addr_i == A_SHAPE) shape_o <= wr_data_i;
      if (wr_addr_i == A_BOOST) boost_o <= wr_data_i;
      if (wr_addr_i == A_AUDIO) audio_o <= wr_data_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [BYTE_W-1:0] stage_r, active_r;
    logic stage_we;
    assign stage_we = wr_stb_i && (wr_addr_i == A_CH0 + PTR_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_r <= '0;
      else if (stage_we) stage_r <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_r <= '0;
      else if (commit_we) active_r <= stage_r;
    end

    assign stage_flat[c*BYTE_W +: BYTE_W]  = stage_r;
    assign ch_level_o[c*LVL_W +: LVL_W]    = active_r[LVL_W-1:0];
    assign ch_ramp_o[c*RT_W +: RT_W]       = active_r[LVL_W +: RT_W];
  end

  assign ch_sel = CH_IW'(rd_addr_i - A_CH0);

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_ID:    rd_data_o = DEV_ID;
      A_SYS:   rd_data_o = {ovt_o, 6'b0, en_o};
      A_FREQ:  rd_data_o = freq_o;
      A_SHAPE: rd_data_o = shape_o;
      A_BOOST: rd_data_o = boost_o;
      A_AUDIO: rd_data_o = audio_o;
      default: if (rd_addr_i >= A_CH0 && rd_addr_i < A_COMMIT)
                 rd_data_o = stage_flat[ch_sel*BYTE_W +: BYTE_W];
    endcase
  end
endmodule

// File: rtl/lamp_i2c_regbank.sv
module lamp_i2c_regbank
  import lampreg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic [1:0]              strap_i,
  input  logic                    ovt_evt_i,
  output logic                    sda_low_o,
  output logic                    lamp_en_o,
  output logic [7:0]              el_freq_o,
  output logic                    damp_en_o,
  output logic [1:0]              wave_shape_o,
  output logic [1:0]              slope_o,
  output logic [1:0]              spread_o,
  output logic [4:0]              boost_freq_o,
  output logic                    aux_fm_o,
  output logic                    aux_follow_o,
  output logic [1:0]              aux_div_o,
  output logic [NUM_CH-1:0]       aux_ch_en_o,
  output logic [NUM_CH*LVL_W-1:0] ch_level_o,
  output logic [NUM_CH*RT_W-1:0]  ch_ramp_o,
  output logic                    ovt_o
);
  logic [1:0] rst_pipe;
  logic rst_core_n;
  logic scl_rise, scl_fall, start_det, stop_det, wr_stb;
  logic [PTR_W-1:0]  wr_addr, ptr;
  logic [BYTE_W-1:0] wr_data, rd_data, shape_b, boost_b, audio_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2c_line_events u_ev (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_link_fsm u_link (
    .clk(clk), .rst_n(rst_core_n), .sda_i(sda_i),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .strap_i(strap_i),
    .rd_data_i(rd_data), .sda_low_o(sda_low_o), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .ptr_o(ptr)
  );

  lamp_regfile u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(ptr), .ovt_evt_i(ovt_evt_i),
    .rd_data_o(rd_data), .en_o(lamp_en_o), .ovt_o(ovt_o),
    .freq_o(el_freq_o), .shape_o(shape_b), .boost_o(boost_b), .audio_o(audio_b),
    .ch_level_o(ch_level_o), .ch_ramp_o(ch_ramp_o)
  );

  assign damp_en_o    = shape_b[6];
  assign wave_shape_o = shape_b[3:2];
  assign slope_o      = shape_b[1:0];
  assign spread_o     = boost_b[7:6];
  assign boost_freq_o = boost_b[4:0];
  assign aux_fm_o     = audio_b[7];
  assign aux_follow_o = audio_b[6];
  assign aux_div_o    = audio_b[5:4];
  assign aux_ch_en_o  = audio_b[NUM_CH-1:0];
endmodule

// File: rtl/lamp_i2c_regbank_chk.sv
module lamp_i2c_regbank_chk
  import lampreg_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scl_i,
  input logic                    sda_low_o,
  input logic                    wr_stb,
  input logic [PTR_W-1:0]        wr_addr,
  input logic [PTR_W-1:0]        ptr,
  input logic                    ovt_o,
  input logic                    lamp_en_o,
  input logic [NUM_CH*LVL_W-1:0] ch_level_o,
  input logic [NUM_CH*RT_W-1:0]  ch_ramp_o
);
  p_ptr_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= REG_LAST);

  p_commit_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ch_level_o, ch_ramp_o}) |-> $past(wr_stb && wr_addr == A_COMMIT));

  p_ovt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovt_o |=> ovt_o);

  p_ack_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> sda_low_o);

  p_drive_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> !scl_i);

  p_enable_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lamp_en_o) |-> $past(wr_stb && wr_addr == A_SYS));
endmodule

bind lamp_i2c_regbank lamp_i2c_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_low_o(sda_low_o),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .ptr(ptr), .ovt_o(ovt_o),
  .lamp_en_o(lamp_en_o), .ch_level_o(ch_level_o), .ch_ramp_o(ch_ramp_o)
);

// File: tb/lamp_i2c_regbank_tb.sv
module lamp_i2c_regbank_tb;
  import lampreg_pkg::*;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n, scl, sda_m, ovt_evt;
  logic [1:0] strap;
  logic sda_low_o, lamp_en_o, damp_en_o, aux_fm_o, aux_follow_o, ovt_o;
  logic [7:0] el_freq_o;
  logic [1:0] wave_shape_o, slope_o, spread_o, aux_div_o;
  logic [4:0] boost_freq_o;
  logic [NUM_CH-1:0] aux_ch_en_o;
  logic [NUM_CH*LVL_W-1:0] ch_level_o;
  logic [NUM_CH*RT_W-1:0] ch_ramp_o;
  wire sda_bus = sda_m & ~sda_low_o;

  always #10 clk = ~clk;

  lamp_i2c_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .ovt_evt_i(ovt_evt), .sda_low_o(sda_low_o), .lamp_en_o(lamp_en_o),
    .el_freq_o(el_freq_o), .damp_en_o(damp_en_o), .wave_shape_o(wave_shape_o),
    .slope_o(slope_o), .spread_o(spread_o), .boost_freq_o(boost_freq_o),
    .aux_fm_o(aux_fm_o), .aux_follow_o(aux_follow_o), .aux_div_o(aux_div_o),
    .aux_ch_en_o(aux_ch_en_o), .ch_level_o(ch_level_o), .ch_ramp_o(ch_ramp_o),
    .ovt_o(ovt_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] mdl [NUM_REGS];
  logic [7:0] mact [NUM_CH];
  logic [7:0] wbuf [16];
  logic m_en, m_ovt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 0) return 8'hB2;
    if (a == 1) return {m_ovt, 6'b0, m_en};
    if (a >= 2 && a <= 9) return mdl[a];
    return 8'h00;
  endfunction

  function automatic int clampp(input int p);
    return (p > 11) ? 11 : p;
  endfunction

  task automatic model_wr(input int a, input logic [7:0] d);
    if (a == 1) m_en = d[0];
    else if (a >= 2 && a <= 9) mdl[a] = d;
    else if (a == 10) for (int c = 0; c < NUM_CH; c++) mact[c] = mdl[6+c];
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM_REGS; i++) mdl[i] = 8'h00;
    for (int c = 0; c < NUM_CH; c++) mact[c] = 8'h00;
    m_en = 1'b0; m_ovt = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(H); scl = 1'b1; tick(H); sda_m = 1'b0; tick(H); scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H); scl = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic pulse, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
    end
    if (pulse) begin ovt_evt = 1'b1; tick(1); ovt_evt = 1'b0; end
    sda_m = 1'b1; tick(pulse ? H-1 : H);
    scl = 1'b1; tick(H/2); ack = ~sda_bus; tick(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl = 1'b1; tick(H/2); b[i] = sda_bus; tick(H/2); scl = 1'b0;
    end
    sda_m = nack; tick(H); scl = 1'b1; tick(H); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic write_regs(input int p, input int n, input int pulse_idx);
    logic a; int q;
    bus_start();
    send_byte({ADDR_HI, strap, 1'b0}, 1'b0, a); chk("R2 address ack", a, 1);
    send_byte(p[7:0], 1'b0, a); chk("R2 pointer ack", a, 1);
    q = clampp(p);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], i == pulse_idx, a); chk("R2 data ack", a, 1);
      if (i == pulse_idx) m_ovt = 1'b1;
      model_wr(q, wbuf[i]); q = (q == 11) ? 11 : q + 1;
    end
    bus_stop();
  endtask

  task automatic read_check(input logic use_ptr, input int p, input int n, input string req);
    logic a; logic [7:0] b; int q;
    bus_start();
    if (use_ptr) begin
      send_byte({ADDR_HI, strap, 1'b0}, 1'b0, a); chk(req, a, 1);
      send_byte(p[7:0], 1'b0, a); chk(req, a, 1);
      bus_start();
    end
    send_byte({ADDR_HI, strap, 1'b1}, 1'b0, a); chk(req, a, 1);
    q = use_ptr ? clampp(p) : 0;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n-1, b); chk(req, b, exp_rd(q));
      q = (q == 11) ? 11 : q + 1;
    end
    bus_stop();
  endtask

  task automatic check_outputs(input string req);
    logic [NUM_CH*LVL_W-1:0] lv; logic [NUM_CH*RT_W-1:0] rt;
    for (int c = 0; c < NUM_CH; c++) begin
      lv[c*LVL_W +: LVL_W] = mact[c][4:0];
      rt[c*RT_W +: RT_W]   = mact[c][7:5];
    end
    chk({req, " R10 freq"}, el_freq_o, mdl[2]);
    chk({req, " R10 shape"}, {damp_en_o, wave_shape_o, slope_o},
        {mdl[3][6], mdl[3][3:2], mdl[3][1:0]});
    chk({req, " R10 boost"}, {spread_o, boost_freq_o}, {mdl[4][7:6], mdl[4][4:0]});
    chk({req, " R10 audio"}, {aux_fm_o, aux_follow_o, aux_div_o, aux_ch_en_o}, mdl[5]);
    chk({req, " R9 levels"}, ch_level_o, lv);
    chk({req, " R9 ramps"}, ch_ramp_o, rt);
    chk({req, " R8 enable"}, lamp_en_o, m_en);
    chk({req, " R11 flag"}, ovt_o, m_ovt);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a; logic [7:0] b;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 2'b01; ovt_evt = 1'b0;
    model_reset();
    tick(5);
    chk("R12 reset drive", sda_low_o, 0);
    check_outputs("R12 reset");
    rst_n = 1'b1; tick(5);

    // R1: sweep every 7-bit address with strap 01
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      send_byte({ad[6:0], 1'b0}, 1'b0, a);
      chk("R1 address match", a, (ad[6:0] == {ADDR_HI, strap}));
      bus_stop();
    end
    // R1: every strap value
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      wbuf[0] = 8'h10 + 8'(s);
      write_regs(2, 1, -1);
      read_check(1'b1, 2, 1, "R1 strap");
    end
    strap = 2'b10;

    // R3, R10: multi-byte write across config and staging
    wbuf[0] = 8'h3C; wbuf[1] = 8'hDA; wbuf[2] = 8'h95; wbuf[3] = 8'hB7;
    wbuf[4] = 8'h21; wbuf[5] = 8'h4E; wbuf[6] = 8'h93; wbuf[7] = 8'hFF;
    write_regs(2, 8, -1);
    check_outputs("R3 before commit");
    read_check(1'b1, 2, 8, "R6 preset pointer");

    // R9: commit
    wbuf[0] = 8'h55; write_regs(10, 1, -1);
    check_outputs("R9 after commit");

    // R5: read from zero, run past the end (R4)
    read_check(1'b0, 0, 14, "R5 read from zero");
    read_check(1'b1, 8'h3F, 2, "R4 pointer clamp");

    // R4: stage ch3, commit and saturate in one frame
    wbuf[0] = 8'h07; wbuf[1] = 8'h99; wbuf[2] = 8'h77; wbuf[3] = 8'h66;
    write_regs(9, 4, -1);
    check_outputs("R4 saturate");
    read_check(1'b1, 9, 3, "R4 read tail");

    // R8: id location ignores writes, enable bit only
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    write_regs(0, 2, -1);
    check_outputs("R8");
    read_check(1'b1, 0, 2, "R8 id and system");

    // R7: master NACK releases the line
    bus_start();
    send_byte({ADDR_HI, strap, 1'b1}, 1'b0, a); chk("R7 address ack", a, 1);
    recv_byte(1'b1, b); chk("R7 first byte", b, 8'hB2);
    recv_byte(1'b1, b); chk("R7 silent after NACK", b, 8'hFF);
    bus_stop();

    // R11: event in same clock as write of 0x00 to location 0x01
    wbuf[0] = 8'h00; write_regs(1, 1, 0);
    check_outputs("R11 concurrent");
    read_check(1'b1, 1, 1, "R11 readback concurrent");
    wbuf[0] = 8'hFF; write_regs(1, 1, -1);
    check_outputs("R11 not cleared");
    read_check(1'b1, 1, 1, "R11 readback");

    // R13: STOP mid-byte
    bus_start();
    send_byte({ADDR_HI, strap, 1'b0}, 1'b0, a); chk("R13 address ack", a, 1);
    send_byte(8'h02, 1'b0, a); chk("R13 pointer ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; tick(H); scl = 1'b1; tick(H); scl = 1'b0;
    end
    bus_stop();
    check_outputs("R13 partial byte dropped");
    read_check(1'b1, 2, 1, "R13 back to idle");

    // R12: traffic during reset is ignored, everything cleared
    rst_n = 1'b0; tick(2);
    bus_start();
    send_byte({ADDR_HI, strap, 1'b0}, 1'b0, a); chk("R12 no ack in reset", a, 0);
    send_byte(8'h02, 1'b0, a);
    send_byte(8'hAA, 1'b0, a);
    bus_stop();
    model_reset();
    check_outputs("R12 cleared");
    rst_n = 1'b1; tick(5);
    read_check(1'b0, 0, 12, "R12 readback");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule